// File: doc/BRIEF.md
# Mode-Qualified Performance Counter Unit

This block holds a small bank of event counters for a processor core, each with its own control register, in the core's system-control register space. A control register chooses one event number and a set of privilege-mode enables. Its counter advances by one in every cycle where the chosen event pulse is high and the core's current privilege state passes those enables. Counters with an even index take events from one event bank and counters with an odd index from another. Events 0 (cycles) and 1 (completed instructions) are shared by both banks.

Software reaches the registers through a simple port: a counter index, a select between control and count, a write strobe and write data. Reads are combinational. A counter whose top bit is set raises the performance-counter interrupt when its interrupt enable is on. The interrupt is a level that stays high until software rewrites that counter or clears the enable. A configuration word advertises that counters exist, and each control register carries a read-only flag that tells software whether another counter follows. Software pauses a counter by clearing its five enable bits. The event selection is kept, so writing the saved control value back resumes counting.

Top module: `perf_ctr_unit`

## Requirements
- R1: After reset every counter reads 0, every control register reads 0 in bits 30:0, and the interrupt output is low.
- R2: The configuration output word has bit 4 set, to show that counters are present, and all of its other bits are 0.
- R3: A control register stores write-data bits 14:0 and reads them back: bit 0 exception-level enable, bit 1 kernel enable, bit 2 supervisor enable, bit 3 user enable, bit 4 interrupt enable, bits 14:5 event number. Bits 30:15 read 0.
- R4: Control bit 31 is read-only. It reads 1 for counter indices 0 to 2 and 0 for index 3, whatever was written to it.
- R5: The core is in kernel mode when the 2-bit mode input is 00, or the exception-level flag is set, or the error-level flag is set. With bit 1 set, the counter counts in kernel mode and in no other mode.
- R6: With bit 0 set, the counter counts whenever the exception-level flag is set. Kernel mode reached by mode 00 alone does not satisfy bit 0.
- R7: Bit 2 passes when the mode input is 01 and bit 3 passes when it is 10. In both cases the exception-level and error-level flags must be clear.
- R8: Event numbers 0 and 1 take the shared pulse inputs bits 0 and 1 on every counter. Event numbers 2 to 15 take bank bits 0 to 13: the even bank for even indices and the odd bank for odd indices. Event numbers 16 and above never count.
- R9: A write to a counter in the same cycle as a qualifying event loads the written value, and that event is not added.
- R10: A counter keeps counting after bit 31 sets and wraps from 0xFFFFFFFF to 0.
- R11: The interrupt output is high while any counter with its interrupt enable set has bit 31 set. It drops when that counter is written with bit 31 clear. Bit 26 of the cause output word mirrors the interrupt, and all other cause bits are 0.
- R12: Writing a control value with bits 4:0 clear stops the counter and withdraws its interrupt while the event number reads back unchanged. Writing the earlier value back resumes counting and the interrupt.
- R13: Counter registers load on write and count on qualifying events from one cycle to the next, and a read returns the updated value in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Counter index for reads and writes |
| reg_sel_cnt | input | 1 | 1 selects the count register, 0 the control register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for the selected register |
| evt_shared | input | 2 | Shared event pulses: bit 0 cycles, bit 1 completed instructions |
| evt_even | input | 14 | Even-bank event pulses for event numbers 2 to 15 |
| evt_odd | input | 14 | Odd-bank event pulses for event numbers 2 to 15 |
| priv_ksu | input | 2 | Privilege mode: 00 kernel, 01 supervisor, 10 user |
| priv_exl | input | 1 | Exception-level flag |
| priv_erl | input | 1 | Error-level flag |
| cfg_word | output | 32 | Configuration word; bit 4 shows counters are present |
| cause_word | output | 32 | Cause status; bit 26 is the pending counter interrupt |
| pmc_irq | output | 1 | Performance-counter interrupt level |

## Verification
The bench aims at the privilege corners. It counts with mode 00 under a kernel enable, then applies the exception-level and error-level flags in user mode. It also shows that the exception-level enable ignores plain mode 00. A filter that treated bit 0 as a general kernel bit, or that ignored the error flag, would give the wrong counts. It drives the same pulse into both banks to catch a counter that reads the wrong bank, and it chooses an event number beyond the wired events to catch aliasing. It collides a counter write with an event, steps a counter over bit 31 and over the wrap, and pauses and resumes with the event field kept. A design that added the event after the write, raised the interrupt on wraparound, or left the interrupt up during a pause would show a wrong count or a wrong interrupt level.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int REG_W        = 32;
  localparam int EVT_W        = 10;
  localparam int CTL_W        = 5 + EVT_W;
  localparam int CHAIN_BIT    = 31;
  localparam int PRESENT_BIT  = 4;
  localparam int CAUSE_IRQ_BIT = 26;

  localparam logic [1:0] KSU_KERNEL = 2'b00;
  localparam logic [1:0] KSU_SUPER  = 2'b01;
  localparam logic [1:0] KSU_USER   = 2'b10;

  // Packed so that exl_en lands on bit 0 and evt on bits 14:5.
  typedef struct packed {
    logic [EVT_W-1:0] evt;
    logic             irq_en;
    logic             user_en;
    logic             sup_en;
    logic             kern_en;
    logic             exl_en;
  } ctl_t;

  function automatic logic in_kernel(input logic [1:0] ksu,
                                     input logic exl, input logic erl);
    return (ksu == KSU_KERNEL) || exl || erl;
  endfunction

  function automatic logic mode_pass(input ctl_t c, input logic [1:0] ksu,
                                     input logic exl, input logic erl);
    logic plain;
    plain = !exl && !erl;
    return (c.exl_en  && exl) ||
           (c.kern_en && in_kernel(ksu, exl, erl)) ||
           (c.sup_en  && plain && (ksu == KSU_SUPER)) ||
           (c.user_en && plain && (ksu == KSU_USER));
  endfunction

endpackage

// File: rtl/pcu_event_pick.sv
module pcu_event_pick #(
  parameter int SHARED_EVT = 2,
  parameter int BANK_EVT   = 14,
  parameter int SEL_W      = 10
) (
  input  logic [SEL_W-1:0]      sel,
  input  logic [SHARED_EVT-1:0] shared,
  input  logic [BANK_EVT-1:0]   bank,
  output logic                  hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < SHARED_EVT; i++)
      if (sel == SEL_W'(i)) hit = shared[i];
    for (int j = 0; j < BANK_EVT; j++)
      if (sel == SEL_W'(SHARED_EVT + j)) hit = bank[j];
  end
endmodule

// File: rtl/pcu_slice.sv
module pcu_slice
  import pcu_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          cnt_we,
  input  ctl_t          ctl_wdata,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [1:0]    ksu,
  input  logic          exl,
  input  logic          erl,
  input  logic          evt_hit,
  output ctl_t          ctl_q,
  output logic [CW-1:0] cnt_q,
  output logic          inc,
  output logic          irq_req
);
  assign inc     = evt_hit && mode_pass(ctl_q, ksu, exl, erl);
  assign irq_req = ctl_q.irq_en && cnt_q[CW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (cnt_we)   cnt_q <= cnt_wdata;     // write beats the increment
      else if (inc) cnt_q <= cnt_q + CW'(1); // wraps modulo 2^CW
    end
  end
endmodule

// File: rtl/pcu_read_mux.sv
module pcu_read_mux
  import pcu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CW      = 32,
  parameter int IDXW    = 2
) (
  input  logic [IDXW-1:0]             idx,
  input  logic                        sel_cnt,
  input  ctl_t [NUM_CTR-1:0]          ctl_bus,
  input  logic [NUM_CTR-1:0][CW-1:0]  cnt_bus,
  output logic [REG_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    if (int'(idx) < NUM_CTR) begin
      if (sel_cnt) begin
        rdata[CW-1:0] = cnt_bus[idx];
      end else begin
        rdata[CTL_W-1:0] = ctl_bus[idx];
        rdata[CHAIN_BIT] = (int'(idx) < NUM_CTR - 1);
      end
    end
  end
endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
  import pcu_pkg::*;
#(
  parameter int NUM_CTR    = 4,
  parameter int CW         = 32,
  parameter int SHARED_EVT = 2,
  parameter int BANK_EVT   = 14,
  localparam int IDXW      = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [IDXW-1:0]       reg_idx,
  input  logic                  reg_sel_cnt,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [SHARED_EVT-1:0] evt_shared,
  input  logic [BANK_EVT-1:0]   evt_even,
  input  logic [BANK_EVT-1:0]   evt_odd,
  input  logic [1:0]            priv_ksu,
  input  logic                  priv_exl,
  input  logic                  priv_erl,
  output logic [REG_W-1:0]      cfg_word,
  output logic [REG_W-1:0]      cause_word,
  output logic                  pmc_irq
);
  // Named internal events, visible to the bound checker.
  ctl_t [NUM_CTR-1:0]          ctl_bus;
  logic [NUM_CTR-1:0][CW-1:0]  cnt_bus;
  logic [NUM_CTR-1:0][4:0]     ctl_en_bus;
  logic [NUM_CTR-1:0]          cnt_wr;
  logic [NUM_CTR-1:0]          ctl_wr;
  logic [NUM_CTR-1:0]          cnt_inc;
  logic [NUM_CTR-1:0]          irq_vec;

  ctl_t ctl_wdata;
  assign ctl_wdata = ctl_t'(reg_wdata[CTL_W-1:0]);

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic                hit;
    logic [BANK_EVT-1:0] bank;

    if (k % 2 == 0) begin : g_even
      assign bank = evt_even;
    end else begin : g_odd
      assign bank = evt_odd;
    end

    assign cnt_wr[k]     = reg_we && reg_sel_cnt  && (reg_idx == IDXW'(k));
    assign ctl_wr[k]     = reg_we && !reg_sel_cnt && (reg_idx == IDXW'(k));
    assign ctl_en_bus[k] = ctl_bus[k][4:0];

    pcu_event_pick #(
      .SHARED_EVT(SHARED_EVT), .BANK_EVT(BANK_EVT), .SEL_W(EVT_W)
    ) pick_i (
      .sel(ctl_bus[k].evt), .shared(evt_shared), .bank(bank), .hit(hit)
    );

    pcu_slice #(.CW(CW)) slice_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_wr[k]), .cnt_we(cnt_wr[k]),
      .ctl_wdata(ctl_wdata), .cnt_wdata(reg_wdata[CW-1:0]),
      .ksu(priv_ksu), .exl(priv_exl), .erl(priv_erl),
      .evt_hit(hit),
      .ctl_q(ctl_bus[k]), .cnt_q(cnt_bus[k]),
      .inc(cnt_inc[k]), .irq_req(irq_vec[k])
    );
  end

  pcu_read_mux #(.NUM_CTR(NUM_CTR), .CW(CW), .IDXW(IDXW)) rmux_i (
    .idx(reg_idx), .sel_cnt(reg_sel_cnt),
    .ctl_bus(ctl_bus), .cnt_bus(cnt_bus), .rdata(reg_rdata)
  );

  assign pmc_irq = |irq_vec;

  always_comb begin
    cfg_word                = '0;
    cfg_word[PRESENT_BIT]   = 1'b1;
    cause_word              = '0;
    cause_word[CAUSE_IRQ_BIT] = pmc_irq;
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int NUM_CTR = 4,
  parameter int CW      = 32,
  parameter int IDXW    = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [IDXW-1:0]            reg_idx,
  input logic                       reg_sel_cnt,
  input logic [31:0]                reg_wdata,
  input logic [31:0]                reg_rdata,
  input logic [31:0]                cause_word,
  input logic                       pmc_irq,
  input logic [NUM_CTR-1:0][CW-1:0] cnt_bus,
  input logic [NUM_CTR-1:0][4:0]    ctl_en_bus,
  input logic [NUM_CTR-1:0]         cnt_wr
);
  logic any_top;
  always_comb begin
    any_top = 1'b0;
    for (int k = 0; k < NUM_CTR; k++) any_top = any_top | cnt_bus[k][CW-1];
  end

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
    // R9: a counter write always lands, even with a qualifying event.
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr[k] |=> cnt_bus[k] == $past(reg_wdata[CW-1:0]));
    // R10 / R13: without a write a counter holds or steps by exactly one.
    a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr[k] |=> (cnt_bus[k] == $past(cnt_bus[k])) ||
                     (cnt_bus[k] == $past(cnt_bus[k]) + CW'(1)));
    // R12: with every enable cleared the counter is frozen.
    a_r12_paused_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr[k] && ctl_en_bus[k] == 5'b0) |=> $stable(cnt_bus[k]));
  end

  // R11: the interrupt needs some counter with its top bit set.
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    pmc_irq |-> any_top);

  // R11: cause bit 26 follows the interrupt line.
  a_r11_cause_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    cause_word[26] == pmc_irq);

  // R4: chain flag on control reads.
  always @(posedge clk) begin
    if (rst_n && !reg_sel_cnt && int'(reg_idx) < NUM_CTR)
      a_r4_chain_flag: assert (reg_rdata[31] == (int'(reg_idx) < NUM_CTR - 1));
  end
endmodule

bind perf_ctr_unit pcu_checker #(.NUM_CTR(NUM_CTR), .CW(CW), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_sel_cnt(reg_sel_cnt),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cause_word(cause_word),
  .pmc_irq(pmc_irq), .cnt_bus(cnt_bus), .ctl_en_bus(ctl_en_bus), .cnt_wr(cnt_wr)
);

// File: tb/perf_ctr_unit_tb_top.sv
module perf_ctr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic        reg_sel_cnt = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  evt_shared = '0;
  logic [13:0] evt_even = '0;
  logic [13:0] evt_odd = '0;
  logic [1:0]  priv_ksu = 2'b10;
  logic        priv_exl = 1'b0;
  logic        priv_erl = 1'b0;
  logic [31:0] cfg_word;
  logic [31:0] cause_word;
  logic        pmc_irq;

  always #10 clk = ~clk; // 50 MHz

  perf_ctr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_sel_cnt(reg_sel_cnt), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_shared(evt_shared), .evt_even(evt_even), .evt_odd(evt_odd),
    .priv_ksu(priv_ksu), .priv_exl(priv_exl), .priv_erl(priv_erl),
    .cfg_word(cfg_word), .cause_word(cause_word), .pmc_irq(pmc_irq)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 cause, 3 cfg
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t item;
  logic [31:0] act;
  logic mon_go = 1'b0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Monitor: samples mid-cycle after the edge, well away from driver changes.
  always @(posedge clk) begin
    #5;
    if (mon_go && q.size() > 0) begin
      item = q.pop_front();
      case (item.kind)
        0: act = reg_rdata;
        1: act = {31'b0, pmc_irq};
        2: act = cause_word;
        default: act = cfg_word;
      endcase
      checks++;
      if (act !== item.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", item.tag, act, item.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [1:0] idx,
                             input logic sel, input logic [31:0] exp,
                             input string tag);
    @(negedge clk);
    reg_idx = idx; reg_sel_cnt = sel;
    q.push_back('{kind, exp, tag});
    mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
  endtask

  task automatic rd_cnt(input logic [1:0] idx, input logic [31:0] exp, input string tag);
    expect_item(0, idx, 1'b1, exp, tag);
  endtask

  task automatic rd_ctl(input logic [1:0] idx, input logic [31:0] exp, input string tag);
    expect_item(0, idx, 1'b0, exp, tag);
  endtask

  task automatic chk_irq(input logic v, input string tag);
    expect_item(1, 2'd0, 1'b1, {31'b0, v}, tag);
  endtask

  task automatic wr(input logic [1:0] idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_sel_cnt = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_with_even_evt(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_sel_cnt = 1'b1; reg_wdata = d;
    evt_even = 14'h1;
    @(negedge clk);
    reg_we = 1'b0; evt_even = '0;
  endtask

  task automatic pulse(input int n, input logic [1:0] sh,
                       input logic [13:0] ev, input logic [13:0] od);
    @(negedge clk);
    evt_shared = sh; evt_even = ev; evt_odd = od;
    repeat (n) @(negedge clk);
    evt_shared = '0; evt_even = '0; evt_odd = '0;
  endtask

  task automatic set_priv(input logic [1:0] ksu, input logic exl, input logic erl);
    @(negedge clk);
    priv_ksu = ksu; priv_exl = exl; priv_erl = erl;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 presence, R4 chain flag
    rd_cnt(0, 32'h0, "R1 cnt0 reset");
    rd_cnt(3, 32'h0, "R1 cnt3 reset");
    rd_ctl(0, 32'h8000_0000, "R1 R4 ctl0 reset with chain");
    rd_ctl(3, 32'h0, "R1 R4 ctl3 reset no chain");
    chk_irq(1'b0, "R1 irq low after reset");
    expect_item(3, 0, 0, 32'h0000_0010, "R2 presence word");
    expect_item(2, 0, 0, 32'h0, "R11 cause idle");

    // R3 field storage, R4 read-only chain
    wr(0, 0, 32'hFFFF_FFFF);
    rd_ctl(0, 32'h8000_7FFF, "R3 ctl0 stored bits");
    wr(3, 0, 32'hFFFF_FFFF);
    rd_ctl(3, 32'h0000_7FFF, "R4 ctl3 chain stays 0");
    wr(2, 0, 32'h0);
    rd_ctl(2, 32'h8000_0000, "R4 ctl2 chain stays 1");
    wr(0, 0, 32'h0); wr(3, 0, 32'h0);
    wr(0, 1, 32'h0); wr(3, 1, 32'h0);

    // R7 user and supervisor filters, event 0 shared pulse
    set_priv(2'b10, 0, 0);
    wr(0, 0, 32'h0000_0008);
    pulse(5, 2'b01, '0, '0);
    rd_cnt(0, 32'd5, "R7 user counting R13");
    set_priv(2'b01, 0, 0);
    pulse(3, 2'b01, '0, '0);
    rd_cnt(0, 32'd5, "R7 user enable blocked in supervisor");
    wr(0, 0, 32'h0000_0004);
    pulse(3, 2'b01, '0, '0);
    rd_cnt(0, 32'd8, "R7 supervisor counting");
    set_priv(2'b10, 1, 0);
    pulse(2, 2'b01, '0, '0);
    rd_cnt(0, 32'd8, "R7 supervisor enable blocked under exception level");
    wr(0, 0, 32'h0);

    // R5 kernel definition on odd counter with shared event 1
    set_priv(2'b10, 0, 0);
    wr(1, 0, 32'h0000_0022);
    pulse(4, 2'b10, '0, '0);
    rd_cnt(1, 32'd0, "R5 kernel enable idle in user mode");
    set_priv(2'b00, 0, 0);
    pulse(4, 2'b10, '0, '0);
    rd_cnt(1, 32'd4, "R5 kernel by mode 00");
    set_priv(2'b10, 0, 1);
    pulse(2, 2'b10, '0, '0);
    rd_cnt(1, 32'd6, "R5 kernel by error level");
    set_priv(2'b10, 1, 0);
    pulse(2, 2'b10, '0, '0);
    rd_cnt(1, 32'd8, "R5 kernel by exception level");
    wr(1, 0, 32'h0);

    // R6 exception-level enable
    set_priv(2'b00, 0, 0);
    wr(2, 0, 32'h0000_0001);
    pulse(3, 2'b01, '0, '0);
    rd_cnt(2, 32'd0, "R6 mode 00 alone does not pass");
    set_priv(2'b00, 1, 0);
    pulse(3, 2'b01, '0, '0);
    rd_cnt(2, 32'd3, "R6 exception level passes");
    wr(2, 0, 32'h0);

    // R8 bank selection
    set_priv(2'b10, 0, 0);
    wr(0, 1, 32'h0); wr(1, 1, 32'h0); wr(2, 1, 32'h0);
    wr(0, 0, 32'h0000_0048);
    wr(1, 0, 32'h0000_0048);
    wr(2, 0, 32'h0000_0288);
    rd_ctl(2, 32'h8000_0288, "R3 event field readback");
    pulse(3, 2'b00, 14'h0001, 14'h0000);
    rd_cnt(0, 32'd3, "R8 even counter takes even bank");
    rd_cnt(1, 32'd0, "R8 odd counter ignores even bank");
    pulse(2, 2'b00, 14'h0000, 14'h0001);
    rd_cnt(1, 32'd2, "R8 odd counter takes odd bank");
    rd_cnt(0, 32'd3, "R8 even counter ignores odd bank");
    pulse(3, 2'b11, 14'h3FFF, 14'h3FFF);
    rd_cnt(2, 32'd0, "R8 event 20 never counts");
    rd_cnt(0, 32'd6, "R8 even count all-ones pattern");
    rd_cnt(1, 32'd5, "R8 odd count all-ones pattern");

    // R9 write beats increment
    wr_with_even_evt(0, 32'd100);
    rd_cnt(0, 32'd100, "R9 write wins over event");

    // R10 and R11 overflow, wrap, interrupt level
    wr(3, 0, 32'h0000_0018);
    wr(3, 1, 32'h7FFF_FFFE);
    pulse(1, 2'b01, '0, '0);
    rd_cnt(3, 32'h7FFF_FFFF, "R10 below top bit");
    chk_irq(1'b0, "R11 no irq below top bit");
    pulse(1, 2'b01, '0, '0);
    rd_cnt(3, 32'h8000_0000, "R10 top bit set");
    chk_irq(1'b1, "R11 irq on top bit");
    expect_item(2, 0, 0, 32'h0400_0000, "R11 cause bit 26");
    pulse(2, 2'b01, '0, '0);
    rd_cnt(3, 32'h8000_0002, "R10 counts past top bit");
    chk_irq(1'b1, "R11 irq holds");
    wr(3, 1, 32'hFFFF_FFFF);
    pulse(1, 2'b01, '0, '0);
    rd_cnt(3, 32'h0, "R10 wrap to zero");
    chk_irq(1'b0, "R11 irq drops after wrap");
    wr(3, 1, 32'h8000_0000);
    chk_irq(1'b1, "R11 irq by written top bit");
    wr(3, 1, 32'd5);
    chk_irq(1'b0, "R11 irq cleared by write");
    wr(0, 1, 32'h8000_0000);
    chk_irq(1'b0, "R11 top bit without interrupt enable");

    // R12 pause keeps event, resume restores
    wr(3, 0, 32'h0000_0038);
    wr(3, 1, 32'h8000_0000);
    chk_irq(1'b1, "R12 armed before pause");
    wr(3, 0, 32'h0000_0020);
    rd_ctl(3, 32'h0000_0020, "R12 event kept while paused");
    chk_irq(1'b0, "R12 irq withdrawn while paused");
    pulse(3, 2'b10, '0, '0);
    rd_cnt(3, 32'h8000_0000, "R12 frozen while paused");
    wr(3, 0, 32'h0000_0038);
    chk_irq(1'b1, "R12 irq back on resume");
    pulse(2, 2'b10, '0, '0);
    rd_cnt(3, 32'h8000_0002, "R12 counting resumed");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule